// File: doc/BRIEF.md
# Threshold-Interrupt Parallel Port FIFO

A 16-byte first-in first-out buffer that sits between a host register interface and the data path of a parallel port. One select input sets the transfer direction. In the forward direction the host writes bytes in and the port side pops them out. In the reverse direction the port side pushes bytes in and the host reads them out. The head byte is always visible on one output, so a read or pop strobe takes the byte shown in that cycle.

A 4-bit threshold, shared by both directions, controls one service interrupt. In the reverse direction the interrupt asks the host to read once enough bytes are waiting. In the forward direction it asks the host to write once enough space is free. A service mask bit holds the interrupt low. Full and empty flags tell the host when it can fill or drain the whole buffer in one burst.

Top module: `ppf_thresh_fifo`

## Requirements
- R1: Bytes leave in the order they entered, and `head_data` always shows the oldest stored byte while the buffer is not empty.
- R2: With `dir_rev`=1, `per_push` stores `per_wdata` and `host_rd` removes the head byte, while `host_wr` and `per_pop` have no effect. With `dir_rev`=0, `host_wr` stores `host_wdata` and `per_pop` removes the head byte, while `per_push` and `host_rd` have no effect.
- R3: With `dir_rev`=1 and `svc_mask`=0, `irq` is 1 exactly when `fill_level` >= 16 - `thresh`. For example, with `thresh`=12 it is 1 for levels 4 to 16.
- R4: With `dir_rev`=0 and `svc_mask`=0, `irq` is 1 exactly when `fill_level` <= `thresh`. For example, with `thresh`=12 it is 1 for levels 0 to 12.
- R5: While `svc_mask`=1, `irq` is 0 at every level.
- R6: `full` is 1 exactly when `fill_level` is 16, and `empty` is 1 exactly when `fill_level` is 0. `fill_level` is a 5-bit count from 0 to 16.
- R7: A store strobe while the buffer is full is ignored: the level and the stored bytes do not change.
- R8: A remove strobe while the buffer is empty is ignored: the level stays 0.
- R9: In the cycle after `dir_rev` changes, the buffer is empty, and every strobe in the cycle of the change is ignored.
- R10: After reset the buffer is empty with `fill_level`=0, `full`=0 and `empty`=1.
- R11: A store and a remove in the same cycle both take effect, and the level does not change. When the buffer is full, the store is refused and the remove proceeds. When it is empty, the remove is refused and the store proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_rev | input | 1 | 1 = port to host, 0 = host to port |
| thresh | input | 4 | Interrupt threshold |
| svc_mask | input | 1 | 1 holds the interrupt low |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| per_push | input | 1 | Port-side push strobe |
| per_wdata | input | 8 | Port-side push byte |
| per_pop | input | 1 | Port-side pop strobe |
| head_data | output | 8 | Oldest stored byte |
| fill_level | output | 5 | Bytes stored, 0 to 16 |
| full | output | 1 | Buffer holds 16 bytes |
| empty | output | 1 | Buffer holds no bytes |
| irq | output | 1 | Service interrupt |

## Verification
The assertions check these on every cycle: the level never exceeds the depth, a refused store or remove leaves the level unchanged, a direction change empties the buffer, a same-cycle store and remove keep the level, `full` and `empty` are never both set, and the mask holds the interrupt low. Several things need the bench's reference queue and its directed scenarios: byte ordering and head data, the exact threshold edges for each direction (4 against 3 and 12 against 13 at threshold 12), and the proof that strobes belonging to the inactive side change nothing.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  // Port-to-host request: enough bytes are waiting to be read.
  function automatic logic rev_hit(int unsigned lvl, int unsigned thr, int unsigned depth);
    return lvl >= (depth - thr);
  endfunction

  // Host-to-port request: enough space is free to be written.
  function automatic logic fwd_hit(int unsigned lvl, int unsigned thr);
    return lvl <= thr;
  endfunction

endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          put_ok,
  input  logic [AW-1:0] wr_ptr,
  input  logic [DW-1:0] put_data,
  input  logic [AW-1:0] rd_ptr,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (put_ok) mem[wr_ptr] <= put_data;
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rev,
  input  logic          put_req,
  input  logic          take_req,
  output logic          put_ok,
  output logic          take_ok,
  output logic          flush,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

  logic dir_q;
  logic at_full, at_empty;

  assign at_full  = (level == LVL_FULL);
  assign at_empty = (level == '0);
  assign flush    = (dir_rev != dir_q);
  assign put_ok   = put_req  && !flush && !at_full;
  assign take_ok  = take_req && !flush && !at_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      dir_q <= dir_rev;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        level  <= '0;
      end else begin
        if (put_ok)  wr_ptr <= wr_ptr + 1'b1;
        if (take_ok) rd_ptr <= rd_ptr + 1'b1;
        case ({put_ok, take_ok})
          2'b10:   level <= level + 1'b1;
          2'b01:   level <= level - 1'b1;
          default: level <= level;
        endcase
      end
    end
  end

  a_r6_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_FULL);

  a_r7_full_store_held: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && at_full && !take_req && !flush) |=> (level == LVL_FULL));

  a_r8_empty_take_held: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && at_empty && !put_req && !flush) |=> (level == '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && (wr_ptr == rd_ptr));

  a_r11_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (put_ok && take_ok) |=> $stable(level));
endmodule

// File: rtl/ppf_irq.sv
module ppf_irq #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          dir_rev,
  input  logic          svc_mask,
  input  logic [AW-1:0] thresh,
  input  logic [CW-1:0] level,
  output logic          irq
);
  import ppf_pkg::*;

  logic rev_req, fwd_req;

  assign rev_req = rev_hit(int'(level), int'(thresh), DEPTH);
  assign fwd_req = fwd_hit(int'(level), int'(thresh));
  assign irq     = !svc_mask && (dir_rev ? rev_req : fwd_req);
endmodule

// File: rtl/ppf_thresh_fifo.sv
module ppf_thresh_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rev,
  input  logic [AW-1:0] thresh,
  input  logic          svc_mask,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          per_push,
  input  logic [DW-1:0] per_wdata,
  input  logic          per_pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] fill_level,
  output logic          full,
  output logic          empty,
  output logic          irq
);
  logic          put_req, take_req, put_ok, take_ok, flush;
  logic [DW-1:0] put_data;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;

  // The direction selects which side stores and which side removes.
  assign put_req  = dir_rev ? per_push  : host_wr;
  assign take_req = dir_rev ? host_rd   : per_pop;
  assign put_data = dir_rev ? per_wdata : host_wdata;

  ppf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .dir_rev, .put_req, .take_req,
    .put_ok, .take_ok, .flush, .wr_ptr, .rd_ptr, .level
  );

  ppf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk, .put_ok, .wr_ptr, .put_data, .rd_ptr, .head(head_data)
  );

  ppf_irq #(.DEPTH(DEPTH)) u_irq (
    .dir_rev, .svc_mask, .thresh, .level, .irq
  );

  assign fill_level = level;
  assign full       = (level == CW'(DEPTH));
  assign empty      = (level == '0);

  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    svc_mask |-> !irq);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r2_store_ok_needs_side: assert property (@(posedge clk) disable iff (!rst_n)
    put_ok |-> (dir_rev ? per_push : host_wr));
endmodule

// File: tb/test_ppf_thresh_fifo.sv
module test_ppf_thresh_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_rev = 1'b0, svc_mask = 1'b0;
  logic [3:0] thresh = 4'd12;
  logic       host_wr = 0, host_rd = 0, per_push = 0, per_pop = 0;
  logic [7:0] host_wdata = 0, per_wdata = 0;
  logic [7:0] head_data;
  logic [4:0] fill_level;
  logic       full, empty, irq;

  int total = 0, bad = 0;
  bit done = 0;
  byte unsigned q[$];
  logic dir_prev = 1'b0;

  always #10 clk = ~clk;

  ppf_thresh_fifo i_ppf_thresh_fifo (
    .clk, .rst_n, .dir_rev, .thresh, .svc_mask, .host_wr, .host_wdata,
    .host_rd, .per_push, .per_wdata, .per_pop, .head_data, .fill_level,
    .full, .empty, .irq
  );

  // Behavioural reference: a queue updated on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      q = {};
      dir_prev = 1'b0;
    end else begin
      if (dir_rev != dir_prev) q = {};
      else begin
        bit st, rm;
        int n;
        n  = q.size();
        st = (dir_rev ? per_push : host_wr) && n < 16;
        rm = (dir_rev ? host_rd : per_pop) && n > 0;
        if (rm) void'(q.pop_front());
        if (st) q.push_back(dir_rev ? per_wdata : host_wdata);
      end
      dir_prev = dir_rev;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_irq();
    int n = q.size();
    if (svc_mask) return 0;
    return dir_rev ? int'(n >= 16 - int'(thresh)) : int'(n <= int'(thresh));
  endfunction

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 level", fill_level, q.size());
      chk("R6 full", full, q.size() == 16);
      chk("R6 empty", empty, q.size() == 0);
      chk(svc_mask ? "R5 irq" : (dir_rev ? "R3 irq" : "R4 irq"), irq, exp_irq());
      if (q.size() > 0) chk("R1 head", head_data, q[0]);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; per_push = 0; per_pop = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 level", fill_level, 0);
    chk("R10 empty", empty, 1);
    chk("R10 full", full, 0);
    rst_n = 1;
    tick();

    // Forward fill with ignored port-side pushes (R2), then overfill (R7).
    for (int i = 0; i < 16; i++) begin
      host_wr = 1; host_wdata = 8'(i * 3 + 1); per_push = 1; per_wdata = 8'hEE;
      tick();
      if (i == 11) begin idle(); chk("R4 irq at 12", irq, 1); end
      if (i == 12) begin idle(); chk("R4 irq at 13", irq, 0); end
    end
    idle();
    chk("R2 per_push ignored fwd", fill_level, 16);
    host_wr = 1; host_wdata = 8'h77;
    tick(); idle();
    chk("R7 level full", fill_level, 16);
    chk("R7 head kept", head_data, 1);
    host_rd = 1;
    tick(); idle();
    chk("R2 host_rd ignored fwd", fill_level, 16);

    // Simultaneous at full: store refused, remove proceeds (R11).
    host_wr = 1; host_wdata = 8'h55; per_pop = 1;
    tick(); idle();
    chk("R11 full both", fill_level, 15);

    // Drain in order (R1).
    for (int i = 1; i < 16; i++) begin
      chk("R1 order", head_data, (i * 3 + 1) & 8'hFF);
      per_pop = 1; tick(); idle();
    end
    chk("R8 drained", fill_level, 0);
    per_pop = 1;
    tick(); idle();
    chk("R8 empty pop", fill_level, 0);

    // Flush on direction change (R9).
    for (int i = 0; i < 5; i++) begin host_wr = 1; host_wdata = 8'(i); tick(); end
    idle();
    chk("R9 pre level", fill_level, 5);
    dir_rev = 1; per_push = 1; per_wdata = 8'h99;
    tick(); idle();
    chk("R9 flushed", fill_level, 0);

    // Reverse direction thresholds (R3) and ignored host writes (R2).
    host_wr = 1;
    tick(); idle();
    chk("R2 host_wr ignored rev", fill_level, 0);
    for (int i = 0; i < 3; i++) begin per_push = 1; per_wdata = 8'(8'hA0 + i); tick(); end
    idle();
    chk("R3 irq at 3", irq, 0);
    per_push = 1; per_wdata = 8'hA3; tick(); idle();
    chk("R3 irq at 4", irq, 1);
    per_pop = 1; tick(); idle();
    chk("R2 per_pop ignored rev", fill_level, 4);
    svc_mask = 1; #1;
    chk("R5 masked", irq, 0);
    svc_mask = 0;
    per_push = 1; per_wdata = 8'hB0; host_rd = 1;
    tick(); idle();
    chk("R11 both level", fill_level, 4);
    chk("R11 head", head_data, 8'hA1);
    thresh = 0; #1;
    chk("R3 thresh0 not full", irq, 0);

    // Empty with both strobes: remove refused, store proceeds (R11).
    dir_rev = 0; tick(); idle();
    host_wr = 1; host_wdata = 8'h3C; per_pop = 1;
    tick(); idle();
    chk("R11 empty both", fill_level, 1);

    // Mixed traffic, compared every cycle.
    for (int i = 0; i < 3000; i++) begin
      host_wr = 1'($urandom_range(0, 1)); host_rd = 1'($urandom_range(0, 1));
      per_push = 1'($urandom_range(0, 1)); per_pop = 1'($urandom_range(0, 2) == 0);
      host_wdata = 8'($urandom); per_wdata = 8'($urandom);
      thresh = 4'($urandom); svc_mask = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 99) == 0) dir_rev = ~dir_rev;
      tick();
    end
    idle();
    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule